// File: doc/BRIEF.md
# CPU-to-I/O Address Window Router

This block decides which downstream I/O port a CPU address belongs to. Software programs four direct windows. Each window is described by three 64-bit registers: a base, a mask and a route. Every window is turned into a registered descriptor that holds an enable, a page-aligned 64-bit base, a 32-bit size and a 2-bit port number. A combinational lookup compares an incoming 64-bit CPU address against the four descriptors. It returns a hit flag and the port of the lowest-numbered window that matches.

The register file also holds the distributed memory window and the two I/O-space windows. The block only stores their values and resets them to fixed defaults. Software can use 8-byte or 4-byte accesses. A 4-byte access touches one 32-bit half of a register, and address bit 2 selects which half. Whenever software writes any register of a window, the block recomputes that window's descriptor. The window is switched off for the one cycle in which the descriptor is out of date.

Top module: `addr_window_router`

## Requirements
- R1: Direct window k (k = 0..3) has its base at offset 0x300 + 24k, its mask at 0x308 + 24k and its route at 0x310 + 24k. The register file spans the offsets 0x300 through 0x3d0. An 8-byte read returns the stored 64-bit value unchanged.
- R2: When `req_wide` is 0 the access is 4 bytes wide. If `req_addr[2]` is 1 the access uses bits 63:32, otherwise bits 31:0. A 4-byte write takes `req_wdata[31:0]` into that half only. A 4-byte read returns that half in `rsp_rdata[31:0]`, with bits 63:32 zero.
- R3: After reset, every register reads 0 except these:
  - 0x360 reads MEM_DIST_BASE with bit 0 set.
  - 0x368 reads 0xfc000000.
  - 0x390 reads IO_DIST_BASE with bit 0 set.
  - 0x398 reads 0xffffff0000.
  - 0x3a0 reads IO_DIST_ROUTE, which is nonzero.
  - 0x3c0 reads 0xfffee00000.
  - 0x3c8 reads 0xffffff0000.
- R4: An access to an offset below 0x300 or at 0x3d8 or above raises `rsp_err` in the same cycle, with `rsp_rdata` equal to 0. A write to such an offset changes no register.
- R5: The effective base of a window is its base register with bits 63:32 forced to ones and bits 11:0 cleared. An address whose upper 32 bits are not all ones therefore never hits.
- R6: The window size is the bitwise NOT of mask bits 31:0, plus one, computed in 32 bits, with bits 11:0 then cleared. An address hits a window when effective base <= address < effective base + size.
- R7: A window takes part in the lookup only when bit 0 of its base register is 1 and its size is nonzero. A mask of 0 or of 0xffffffff gives a size of zero.
- R8: The port reported for a window is bits 1:0 of its route register. All higher route bits are ignored.
- R9: When several enabled windows contain the address, `hit_port` comes from the lowest-numbered one.
- R10: A register write is accepted at a clock edge. During the cycle after that edge, the window written to takes no part in the lookup. From the following edge on, the lookup uses the new values.
- R11: When no window matches, `hit` is 0 and `hit_port` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, combinational |
| rsp_err | output | 1 | Decode error for an unmapped offset |
| cpu_addr | input | 64 | CPU address to route |
| hit | output | 1 | Address falls in an enabled window |
| hit_port | output | 2 | Downstream port of the winning window |

## Verification
The lookup is exercised with addresses in several positions:
- Addresses at the first and last byte of each window, and one byte past the end, expose off-by-one errors in the bounds.
- Addresses just below a window, or with upper bits that are not all ones, show whether the upper 32 bits of the base are forced to ones.
- Addresses in the region where two windows overlap show the priority order. The overlap is probed again after the lower window is disabled.
- Window sizes built from masks of 0 and all ones separate the size-zero disable from the enable bit.
- A probe in the cycle just after a write, and again one cycle later, distinguishes the one-cycle dead period from an immediate or a late update.

Mixed 4-byte and 8-byte accesses show whether each half of a register is merged without disturbing the other half.

// File: rtl/addr_win_pkg.sv
// Shared constants and the window descriptor type for the address window router.
package addr_win_pkg;
    localparam int PORT_W     = 2;   // downstream port index width
    localparam int PAGE_SHIFT = 12;  // window granularity (4 KB)
    localparam int REG_W      = 64;

    // Decoded, ready-to-compare form of one direct window
    typedef struct packed {
        logic              en;
        logic [63:0]       base;
        logic [31:0]       size;
        logic [PORT_W-1:0] port;
    } win_desc_t;
endpackage

// File: rtl/awr_regfile.sv
// Range register file: window registers plus distributed-window storage.
// Assumes: offsets are byte addresses, 4-byte accesses choose a half with
// bit 2, and 8-byte accesses ignore bit 2. Reads are answered in the same cycle.
module awr_regfile
    import addr_win_pkg::*;
#(
    parameter int          OFFS_W        = 12,
    parameter int          BASE_OFF      = 'h300,
    parameter int          NUM_WIN       = 4,
    parameter logic [63:0] MEM_DIST_BASE = 64'h0000_0000_F400_0000,
    parameter logic [63:0] IO_DIST_BASE  = 64'h0000_00FF_FC00_0000,
    parameter logic [63:0] IO_DIST_ROUTE = 64'h0000_0000_0000_0E1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [OFFS_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [63:0]       win_regs_o [3*NUM_WIN],
    output logic [NUM_WIN-1:0] wr_win_o
);
    localparam int NUM_REGS     = 3*NUM_WIN + 15;
    localparam int IDX_W        = $clog2(NUM_REGS);
    localparam int MEM_DIST_IDX = 3*NUM_WIN;
    localparam int IO_DIST_IDX  = MEM_DIST_IDX + 6;
    localparam int IO_DIR_IDX   = MEM_DIST_IDX + 12;
    localparam logic [OFFS_W-1:0] BASE_L = OFFS_W'(BASE_OFF);
    localparam logic [OFFS_W-1:0] END_L  = OFFS_W'(BASE_OFF + 8*NUM_REGS);

    logic [63:0]       regs [NUM_REGS];
    logic [OFFS_W-1:0] rel;
    logic [IDX_W-1:0]  idx;
    logic              in_map;
    logic              wr_acc;
    logic [63:0]       sel_reg;

    // Reset value of each register slot
    function automatic logic [63:0] rst_val(input int i);
        if (i == MEM_DIST_IDX)          return MEM_DIST_BASE | 64'h1;
        else if (i == MEM_DIST_IDX + 1) return 64'h0000_0000_FC00_0000;
        else if (i == IO_DIST_IDX)      return IO_DIST_BASE | 64'h1;
        else if (i == IO_DIST_IDX + 1)  return 64'h0000_00FF_FFFF_0000;
        else if (i == IO_DIST_IDX + 2)  return IO_DIST_ROUTE;
        else if (i == IO_DIR_IDX)       return 64'h0000_00FF_FEE0_0000;
        else if (i == IO_DIR_IDX + 1)   return 64'h0000_00FF_FFFF_0000;
        else                            return 64'h0;
    endfunction

    // Offset decode: slot index and whether the offset maps to a register
    always_comb begin
        rel    = req_addr - BASE_L;
        idx    = IDX_W'(rel >> 3);
        in_map = (req_addr >= BASE_L) && (req_addr < END_L);
        wr_acc = req_valid && req_write && in_map;
    end

    // Register storage with half-word merging on 4-byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= rst_val(i);
        end else if (wr_acc) begin
            if (req_wide)         regs[idx]        <= req_wdata;
            else if (req_addr[2]) regs[idx][63:32] <= req_wdata[31:0];
            else                  regs[idx][31:0]  <= req_wdata[31:0];
        end
    end

    // Read path: whole register or the selected half, zero when unmapped
    always_comb begin
        sel_reg   = in_map ? regs[idx] : 64'h0;
        rsp_err   = req_valid && !in_map;
        if (!in_map)          rsp_rdata = 64'h0;
        else if (req_wide)    rsp_rdata = sel_reg;
        else if (req_addr[2]) rsp_rdata = {32'h0, sel_reg[63:32]};
        else                  rsp_rdata = {32'h0, sel_reg[31:0]};
    end

    // Direct window registers and per-window write strobes
    for (genvar r = 0; r < 3*NUM_WIN; r++) begin : g_out
        assign win_regs_o[r] = regs[r];
    end
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_wr
        assign wr_win_o[k] = wr_acc && (idx >= IDX_W'(3*k)) && (idx < IDX_W'(3*k+3));
    end

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'h0));

    // R2
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !req_wide && !req_addr[2]) |=>
            (regs[$past(idx)][63:32] == $past(regs[idx][63:32])));
endmodule

// File: rtl/awr_window_calc.sv
// Turns each window's base/mask/route registers into a registered descriptor.
// Assumes: a write strobe for a window is raised in the cycle its register is
// written; that window is held disabled during the cycle after the write.
module awr_window_calc
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [63:0]  win_regs_i [3*NUM_WIN],
    input  logic [NUM_WIN-1:0] wr_win_i,
    output win_desc_t    win_o [NUM_WIN]
);
    localparam logic [31:0] PAGE_MASK = ~((32'h1 << PAGE_SHIFT) - 32'h1);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        logic [63:0] raw_base;
        logic [63:0] raw_mask;
        logic [63:0] raw_route;
        win_desc_t   nxt;
        win_desc_t   cur_q;
        logic        pend_q;
        logic        unused_bits;

        // Decode base extension, page alignment, size and port
        always_comb begin
            raw_base  = win_regs_i[3*k];
            raw_mask  = win_regs_i[3*k+1];
            raw_route = win_regs_i[3*k+2];
            nxt.base  = {32'hFFFF_FFFF, raw_base[31:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
            nxt.size  = (~raw_mask[31:0] + 32'h1) & PAGE_MASK;
            nxt.port  = raw_route[PORT_W-1:0];
            nxt.en    = raw_base[0] && (nxt.size != 32'h0);
        end
        assign unused_bits = ^{raw_base[63:32], raw_base[PAGE_SHIFT-1:1],
                               raw_mask[63:32], raw_route[63:PORT_W]};

        // Descriptor register and one-cycle stale marker
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                cur_q  <= nxt;
                pend_q <= wr_win_i[k];
            end
        end

        // Publish the descriptor, masked while stale
        always_comb begin
            win_o[k]    = cur_q;
            win_o[k].en = cur_q.en && !pend_q;
        end

        // R7
        en_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_o[k].en |-> (win_o[k].size != 32'h0));

        // R5
        base_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_o[k].en |-> ((&win_o[k].base[63:32]) &&
                             (win_o[k].base[PAGE_SHIFT-1:0] == '0)));

        // R10
        stale_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_win_i[k] |=> !win_o[k].en);
    end
endmodule

// File: rtl/awr_match.sv
// Priority lookup of a CPU address against the window descriptors.
// Assumes: descriptors are already page-aligned; window 0 has top priority.
module awr_match
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_desc_t         win_i [NUM_WIN],
    input  logic [63:0]       cpu_addr,
    output logic              hit,
    output logic [PORT_W-1:0] hit_port
);
    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [SEL_W-1:0] sel;

    // Scan high to low so the lowest-numbered match is left standing
    always_comb begin
        hit      = 1'b0;
        hit_port = '0;
        sel      = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (win_i[k].en && (cpu_addr >= win_i[k].base) &&
                ({1'b0, cpu_addr} < ({1'b0, win_i[k].base} + {33'h0, win_i[k].size}))) begin
                hit      = 1'b1;
                hit_port = win_i[k].port;
                sel      = SEL_W'(k);
            end
        end
    end

    // R9
    sel_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> win_i[sel].en);

    // R11
    miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_port == '0));
endmodule

// File: rtl/addr_window_router.sv
// Top level: range register file, window descriptor stage and lookup.
// Assumes: the register port and the lookup port share one clock; lookup
// results are combinational from the registered descriptors.
module addr_window_router
    import addr_win_pkg::*;
#(
    parameter int          OFFS_W        = 12,
    parameter int          BASE_OFF      = 'h300,
    parameter int          NUM_WIN       = 4,
    parameter logic [63:0] MEM_DIST_BASE = 64'h0000_0000_F400_0000,
    parameter logic [63:0] IO_DIST_BASE  = 64'h0000_00FF_FC00_0000,
    parameter logic [63:0] IO_DIST_ROUTE = 64'h0000_0000_0000_0E1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [OFFS_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [63:0]       cpu_addr,
    output logic              hit,
    output logic [PORT_W-1:0] hit_port
);
    logic [63:0]        win_regs [3*NUM_WIN];
    logic [NUM_WIN-1:0] wr_win;
    win_desc_t          win [NUM_WIN];

    awr_regfile #(
        .OFFS_W(OFFS_W), .BASE_OFF(BASE_OFF), .NUM_WIN(NUM_WIN),
        .MEM_DIST_BASE(MEM_DIST_BASE), .IO_DIST_BASE(IO_DIST_BASE),
        .IO_DIST_ROUTE(IO_DIST_ROUTE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .win_regs_o(win_regs), .wr_win_o(wr_win)
    );

    awr_window_calc #(.NUM_WIN(NUM_WIN)) u_calc (
        .clk(clk), .rst_n(rst_n), .win_regs_i(win_regs),
        .wr_win_i(wr_win), .win_o(win)
    );

    awr_match #(.NUM_WIN(NUM_WIN)) u_match (
        .clk(clk), .rst_n(rst_n), .win_i(win), .cpu_addr(cpu_addr),
        .hit(hit), .hit_port(hit_port)
    );
endmodule

// File: tb/sim_addr_window_router.sv
module sim_addr_window_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b1;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [63:0] cpu_addr = '0;
    logic        hit;
    logic [1:0]  hit_port;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_window_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cpu_addr(cpu_addr),
        .hit(hit), .hit_port(hit_port)
    );

    // Lookup vectors: {address, expected hit, expected port}
    localparam logic [66:0] VEC [0:10] = '{
        {64'hFFFF_FFFF_1000_0000, 1'b1, 2'd1},  // R6 first byte of w0
        {64'hFFFF_FFFF_100F_FFFF, 1'b1, 2'd1},  // R6 last byte of w0
        {64'hFFFF_FFFF_1010_0000, 1'b0, 2'd0},  // R6 one past end
        {64'hFFFF_FFFF_0FFF_FFFF, 1'b0, 2'd0},  // R6 just below
        {64'hFFFF_FFFF_1008_0000, 1'b1, 2'd1},  // R9 overlap, w0 wins
        {64'hFFFF_FFFF_2000_0000, 1'b0, 2'd0},  // R7 enable bit clear
        {64'hFFFF_FFFF_3000_0000, 1'b1, 2'd3},  // R8 route 7 -> port 3
        {64'hFFFF_FFFF_3000_0FFF, 1'b1, 2'd3},  // R5 base aligned down
        {64'hFFFF_FFFF_3000_1000, 1'b0, 2'd0},  // R6 4 KB window end
        {64'h0000_0000_1000_0000, 1'b0, 2'd0},  // R5 upper bits not ones
        {64'h1234_5678_3000_0000, 1'b0, 2'd0}   // R5 raw upper bits unused
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] off, input logic [63:0] d, input logic wide);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide;
        req_addr = off; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] off, input logic wide,
                          output logic [63:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = off;
        #1;
        d = rsp_rdata; e = rsp_err;
        req_valid = 1'b0;
    endtask

    task automatic probe(input logic [63:0] a, output logic h, output logic [1:0] p);
        cpu_addr = a;
        #1;
        h = hit; p = hit_port;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic        e;
        logic        h;
        logic [1:0]  p;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset values
        reg_rd(12'h300, 1'b1, d, e); check("R3 w0 base", d, 64'h0);
        reg_rd(12'h360, 1'b1, d, e); check("R3 mem dist base", d, 64'h0000_0000_F400_0001);
        reg_rd(12'h368, 1'b1, d, e); check("R3 mem dist mask", d, 64'hFC00_0000);
        reg_rd(12'h390, 1'b1, d, e); check("R3 io dist base", d, 64'h0000_00FF_FC00_0001);
        reg_rd(12'h398, 1'b1, d, e); check("R3 io dist mask", d, 64'hFF_FFFF_0000);
        reg_rd(12'h3a0, 1'b1, d, e); check("R3 io dist route", d, 64'h0E1B);
        reg_rd(12'h3c0, 1'b1, d, e); check("R3 io direct base", d, 64'hFF_FEE0_0000);
        reg_rd(12'h3c8, 1'b1, d, e); check("R3 io direct mask", d, 64'hFF_FFFF_0000);
        probe(64'hFFFF_FFFF_0000_0000, h, p);
        check("R11 reset miss", {62'h0, h, 1'b0} | {62'h0, p}, 64'h0);

        // Program the four windows (R1 layout)
        reg_wr(12'h300, 64'h0000_0000_1000_0001, 1'b1);
        reg_wr(12'h308, 64'h0000_0000_FFF0_0000, 1'b1);
        reg_wr(12'h310, 64'h5, 1'b1);
        reg_wr(12'h318, 64'h1008_0001, 1'b1);
        reg_wr(12'h320, 64'hFFF8_0000, 1'b1);
        reg_wr(12'h328, 64'h2, 1'b0);
        reg_wr(12'h330, 64'h2000_0000, 1'b1);
        reg_wr(12'h338, 64'hFFFF_0000, 1'b1);
        reg_wr(12'h340, 64'h3, 1'b1);
        reg_wr(12'h348, 64'h1234_5678_3000_0ABD, 1'b1);
        reg_wr(12'h350, 64'hFFFF_F000, 1'b1);
        reg_wr(12'h358, 64'h7, 1'b1);
        @(negedge clk);
        reg_rd(12'h348, 1'b1, d, e); check("R1 raw readback w3 base", d, 64'h1234_5678_3000_0ABD);
        reg_rd(12'h320, 1'b1, d, e); check("R1 readback w1 mask", d, 64'hFFF8_0000);

        // Table-driven lookups
        for (int i = 0; i <= 10; i++) begin
            probe(VEC[i][66:3], h, p);
            check($sformatf("R6 vec%0d hit", i), {63'h0, h}, {63'h0, VEC[i][2]});
            check($sformatf("R8 vec%0d port", i), {62'h0, p}, {62'h0, VEC[i][1:0]});
        end

        // R10: dead cycle after a write, then live
        reg_wr(12'h330, 64'h2000_0001, 1'b0);
        probe(64'hFFFF_FFFF_2000_0010, h, p);
        check("R10 disabled cycle after write", {63'h0, h}, 64'h0);
        @(negedge clk);
        probe(64'hFFFF_FFFF_2000_0010, h, p);
        check("R10 live next cycle hit", {63'h0, h}, 64'h1);
        check("R10 live next cycle port", {62'h0, p}, 64'h3);

        // R9: clear w0 enable, overlap now falls to w1
        reg_wr(12'h300, 64'h1000_0000, 1'b1);
        @(negedge clk);
        probe(64'hFFFF_FFFF_1008_0000, h, p);
        check("R9 overlap after w0 off port", {61'h0, h, p}, {61'h0, 1'b1, 2'd2});

        // R7: zero-size masks disable a window
        reg_wr(12'h350, 64'h0, 1'b1);
        @(negedge clk);
        probe(64'hFFFF_FFFF_3000_0000, h, p);
        check("R7 mask zero miss", {63'h0, h}, 64'h0);
        reg_wr(12'h350, 64'hFFFF_FFFF, 1'b1);
        @(negedge clk);
        probe(64'hFFFF_FFFF_3000_0000, h, p);
        check("R7 mask all ones miss", {63'h0, h}, 64'h0);

        // R2: upper-half write and half reads; R8 upper route bits ignored
        reg_wr(12'h32C, 64'hFFFF_FFFF_0000_DEAD, 1'b0);
        reg_rd(12'h328, 1'b1, d, e); check("R2 merged route", d, 64'h0000_DEAD_0000_0002);
        reg_rd(12'h32C, 1'b0, d, e); check("R2 upper half read", d, 64'hDEAD);
        reg_rd(12'h328, 1'b0, d, e); check("R2 lower half read", d, 64'h2);
        @(negedge clk);
        probe(64'hFFFF_FFFF_1008_0000, h, p);
        check("R8 route upper bits ignored", {61'h0, h, p}, {61'h0, 1'b1, 2'd2});

        // R4: decode errors and no side effect
        reg_rd(12'h3D8, 1'b1, d, e);
        check("R4 past end err", {63'h0, e}, 64'h1);
        check("R4 past end data", d, 64'h0);
        reg_rd(12'h2F8, 1'b1, d, e);
        check("R4 below start err", {63'h0, e}, 64'h1);
        reg_rd(12'h3D0, 1'b1, d, e);
        check("R4 last slot mapped", {63'h0, e}, 64'h0);
        reg_wr(12'h2F8, 64'h1234, 1'b1);
        reg_rd(12'h300, 1'b1, d, e);
        check("R4 unmapped write no effect", d, 64'h1000_0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule